// File: doc/BRIEF.md
# Two-Wire Serial Slave Controller

This block is the slave side of a two-wire serial bus (SCL clock, SDA data), oversampled on a fast system clock. It watches the two lines for START and STOP conditions. It answers only an identification byte whose upper nibble is the fixed value 1010 and whose next three bits equal three strap inputs. A write transfer carries an address byte and then exactly one data byte. The controller passes that byte to a separate register bank through a one-cycle write strobe. A read transfer repeats the START, switches direction and then streams bytes from an auto-incrementing pointer for as long as the master acknowledges.

The controller never drives SDA high. It asserts an open-drain pull-down enable for acknowledge bits and for read data zeros. The register bank supplies read data combinationally from the presented address. The bank also drives a busy input while it performs a non-volatile update. While busy is high the controller goes deaf to the bus. A separate one-cycle pulse marks the STOP that closes an accepted write, so the bank knows when to begin such an update.

Top module: `twi_slave_ctrl`

## Requirements
- R1: Out of reset, and whenever the controller is not acknowledging or sending a zero, `sda_oe_o` is 0; `sda_oe_o`=1 means SDA is pulled low.
- R2: An identification byte is acknowledged only when bits 7:4 equal 1010 and bits 3:1 equal `strap_i[2:0]`; bit 0 selects read (1) or write (0).
- R3: In a write, the identification, address and data bytes are each acknowledged, and `reg_we_o` pulses for exactly one cycle with `reg_addr_o` equal to the address byte and `reg_wdata_o` equal to the data byte.
- R4: The write strobe occurs at the SCL falling edge that ends the data byte's least significant bit, before any STOP.
- R5: `nv_start_o` pulses once at the STOP that follows an accepted write data byte, and never after a read.
- R6: With `wp_ni` low, the write data byte receives no acknowledge, produces no write strobe and no `nv_start_o` pulse, and the controller waits for a new START.
- R7: After a repeated START with a read identification byte, data bytes are sent MSB first from the pointer loaded by the address byte, and the pointer advances by one per byte sent.
- R8: The read pointer advances from location `LAST_LOC` (default 8) to 0.
- R9: A master not-acknowledge after a read byte ends transmission: SDA stays released on further SCL clocks until the next START.
- R10: While `busy_i` is high, STARTs and all bus activity are ignored, SDA is released, and no strobe or pulse is issued.
- R11: A STOP in the middle of a byte returns the controller to idle, and the next transfer proceeds normally.
- R12: After a non-matching identification byte, no acknowledge is given and later bytes are ignored until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| strap_i | input | 3 | Address strap bits matched against identification bits 3:1 |
| wp_ni | input | 1 | Write protect, active low |
| busy_i | input | 1 | Register bank busy with a non-volatile update |
| reg_addr_o | output | 8 | Register address (pointer) |
| reg_wdata_o | output | 8 | Write data to the register bank |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_re_o | output | 1 | One-cycle strobe when a read byte is taken |
| reg_rdata_i | input | 8 | Read data from the register bank for `reg_addr_o` |
| nv_start_o | output | 1 | One-cycle pulse at the STOP closing an accepted write |

## Verification
Two events can meet in the same system clock cycle: a START being detected and `busy_i` rising, which must give the busy input priority. The bench raises `busy_i` on the same half-cycle in which it pulls SDA low for a START. It then shows that the following identification byte gets no acknowledge and that no strobe appears. A related collision is a STOP arriving mid-byte, which must override bit reception. The bench judges that case by a clean transfer that follows it.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int STRAP_W = 3;
  localparam int BYTE_W  = 8;
  localparam logic [3:0] ID_PREFIX = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ID,
    ST_ADDR,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_TX_ACK
  } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int NUM    = 2,
  parameter int STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] d_i,
  output logic [NUM-1:0] q_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_line
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= '1;
      else         ff <= {ff[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = ff[STAGES-1];
  end
endmodule

// File: rtl/twi_cond_det.sv
module twi_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // SDA edges while SCL stays high are bus conditions
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
endmodule

// File: rtl/twi_byte_fsm.sv
module twi_byte_fsm
  import twi_pkg::*;
#(
  parameter int LAST_LOC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               wp_ni,
  input  logic               busy_i,
  input  logic [BYTE_W-1:0]  rdata_i,
  output logic               drive_low_o,
  output logic [BYTE_W-1:0]  ptr_o,
  output logic [BYTE_W-1:0]  wdata_o,
  output logic               we_o,
  output logic               re_o,
  output logic               nv_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [BYTE_W-1:0] LAST = BYTE_W'(LAST_LOC);

  twi_state_e        state, ack_next;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx, tx, ptr, wdata;
  logic              drive_low, wr_done, mack, we_q, re_q, nv_q;
  logic              id_ok;

  assign id_ok = (rx[BYTE_W-1 -: 4] == ID_PREFIX) && (rx[STRAP_W:1] == strap_i);

  function automatic logic [BYTE_W-1:0] ptr_next(input logic [BYTE_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      ack_next  <= ST_IDLE;
      bit_cnt   <= '0;
      rx        <= '0;
      tx        <= '0;
      ptr       <= '0;
      wdata     <= '0;
      drive_low <= 1'b0;
      wr_done   <= 1'b0;
      mack      <= 1'b0;
      we_q      <= 1'b0;
      re_q      <= 1'b0;
      nv_q      <= 1'b0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      nv_q <= 1'b0;
      if (busy_i) begin
        state     <= ST_IDLE;
        drive_low <= 1'b0;
        wr_done   <= 1'b0;
      end else if (stop_i) begin
        state     <= ST_IDLE;
        drive_low <= 1'b0;
        nv_q      <= wr_done;
        wr_done   <= 1'b0;
      end else if (start_i) begin
        state     <= ST_ID;
        bit_cnt   <= '0;
        drive_low <= 1'b0;
        wr_done   <= 1'b0;
      end else begin
        unique case (state)
          ST_ID, ST_ADDR, ST_WDATA: begin
            if (rise_i && bit_cnt != FULL) begin
              rx      <= {rx[BYTE_W-2:0], sda_i};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (fall_i && bit_cnt == FULL) begin
              bit_cnt <= '0;
              if (state == ST_ID) begin
                if (id_ok) begin
                  drive_low <= 1'b1;
                  state     <= ST_ACK;
                  ack_next  <= rx[0] ? ST_TX : ST_ADDR;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_ADDR) begin
                ptr       <= rx;
                drive_low <= 1'b1;
                state     <= ST_ACK;
                ack_next  <= ST_WDATA;
              end else if (wp_ni) begin
                we_q      <= 1'b1;
                wdata     <= rx;
                wr_done   <= 1'b1;
                drive_low <= 1'b1;
                state     <= ST_ACK;
                ack_next  <= ST_IDLE;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (fall_i) begin
              bit_cnt <= '0;
              if (ack_next == ST_TX) begin
                tx        <= rdata_i;
                drive_low <= ~rdata_i[BYTE_W-1];
                re_q      <= 1'b1;
              end else begin
                drive_low <= 1'b0;
              end
              state <= ack_next;
            end
          end
          ST_TX: begin
            if (rise_i) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (fall_i && bit_cnt != '0) begin
              if (bit_cnt == FULL) begin
                drive_low <= 1'b0;
                bit_cnt   <= '0;
                ptr       <= ptr_next(ptr);
                state     <= ST_TX_ACK;
              end else begin
                tx        <= {tx[BYTE_W-2:0], 1'b0};
                drive_low <= ~tx[BYTE_W-2];
              end
            end
          end
          ST_TX_ACK: begin
            if (rise_i) begin
              mack    <= ~sda_i;
              bit_cnt <= CNT_W'(1);
            end else if (fall_i && bit_cnt == CNT_W'(1)) begin
              bit_cnt <= '0;
              if (mack) begin
                tx        <= rdata_i;
                drive_low <= ~rdata_i[BYTE_W-1];
                re_q      <= 1'b1;
                state     <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign drive_low_o = drive_low;
  assign ptr_o       = ptr;
  assign wdata_o     = wdata;
  assign we_o        = we_q;
  assign re_o        = re_q;
  assign nv_o        = nv_q;
endmodule

// File: rtl/twi_slave_ctrl.sv
module twi_slave_ctrl
  import twi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LAST_LOC    = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               wp_ni,
  input  logic               busy_i,
  output logic [BYTE_W-1:0]  reg_addr_o,
  output logic [BYTE_W-1:0]  reg_wdata_o,
  output logic               reg_we_o,
  output logic               reg_re_o,
  input  logic [BYTE_W-1:0]  reg_rdata_i,
  output logic               nv_start_o
);
  logic [1:0] lines_s;
  logic       start, stop, rise, fall;

  twi_line_sync #(.NUM(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );

  twi_cond_det u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (lines_s[1]),
    .sda_i  (lines_s[0]),
    .start_o(start),
    .stop_o (stop),
    .rise_o (rise),
    .fall_o (fall)
  );

  twi_byte_fsm #(.LAST_LOC(LAST_LOC)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .stop_i     (stop),
    .rise_i     (rise),
    .fall_i     (fall),
    .sda_i      (lines_s[0]),
    .strap_i    (strap_i),
    .wp_ni      (wp_ni),
    .busy_i     (busy_i),
    .rdata_i    (reg_rdata_i),
    .drive_low_o(sda_oe_o),
    .ptr_o      (reg_addr_o),
    .wdata_o    (reg_wdata_o),
    .we_o       (reg_we_o),
    .re_o       (reg_re_o),
    .nv_o       (nv_start_o)
  );
endmodule

// File: rtl/twi_slave_ctrl_chk.sv
module twi_slave_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic wp_ni,
  input logic sda_oe_o,
  input logic reg_we_o,
  input logic reg_re_o,
  input logic nv_start_o
);
  a_r10_busy_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !sda_oe_o);

  a_r10_busy_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !(reg_we_o || reg_re_o || nv_start_o));

  a_r3_we_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  a_r6_we_needs_wp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> $past(wp_ni));

  a_r5_nv_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_start_o |=> !nv_start_o);

  a_r5_nv_apart_from_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_start_o |-> !reg_we_o);
endmodule

bind twi_slave_ctrl twi_slave_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_i    (busy_i),
  .wp_ni     (wp_ni),
  .sda_oe_o  (sda_oe_o),
  .reg_we_o  (reg_we_o),
  .reg_re_o  (reg_re_o),
  .nv_start_o(nv_start_o)
);

// File: tb/twi_slave_ctrl_tb.sv
module twi_slave_ctrl_tb;
  localparam int Q = 8;
  localparam int LAST = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic [2:0] strap = 3'b000;
  logic wp_n = 1'b1;
  logic busy = 1'b0;
  logic sda_oe, we, re, nv;
  logic [7:0] addr, wdata, rdata;
  wire sda_bus = ~(m_low | sda_oe);

  logic [7:0] mem [0:LAST];
  logic [7:0] exp_mem [0:LAST];
  int checks = 0, errors = 0;
  int we_cnt = 0, nv_cnt = 0;

  always #2.5 clk = ~clk;

  twi_slave_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_i(strap), .wp_ni(wp_n), .busy_i(busy), .reg_addr_o(addr),
    .reg_wdata_o(wdata), .reg_we_o(we), .reg_re_o(re), .reg_rdata_i(rdata),
    .nv_start_o(nv)
  );

  assign rdata = (addr <= 8'(LAST)) ? mem[addr] : 8'h00;

  always @(posedge clk) begin
    if (we) begin
      we_cnt <= we_cnt + 1;
      if (wdata !== 8'hxx && addr <= 8'(LAST)) mem[addr] <= wdata;
    end
    if (nv) nv_cnt <= nv_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nxt(input int p);
    return (p == LAST) ? 0 : p + 1;
  endfunction

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wcyc(Q);
    scl = 1'b1;   wcyc(Q);
    m_low = 1'b1; wcyc(Q);
    scl = 1'b0;   wcyc(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wcyc(Q);
    scl = 1'b1;   wcyc(Q);
    m_low = 1'b0; wcyc(Q);
  endtask

  task automatic clk_bit(input bit b);
    m_low = ~b; wcyc(Q);
    scl = 1'b1; wcyc(Q);
    scl = 1'b0; wcyc(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) clk_bit(b[i]);
    m_low = 1'b0; wcyc(Q);
    scl = 1'b1; wcyc(Q/2);
    ack = ~sda_bus;
    wcyc(Q/2);
    scl = 1'b0; wcyc(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wcyc(Q);
      scl = 1'b1; wcyc(Q/2);
      d[i] = sda_bus;
      wcyc(Q/2);
      scl = 1'b0;
    end
    wcyc(Q/2);
    m_low = mack; wcyc(Q/2);
    scl = 1'b1; wcyc(Q);
    scl = 1'b0; wcyc(Q/2);
    m_low = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input bit wp_on);
    bit ack;
    int we0, nv0;
    we0 = we_cnt; nv0 = nv_cnt;
    wp_n = ~wp_on;
    bus_start();
    send_byte({4'b1010, strap, 1'b0}, ack);
    chk(ack, "R2 id ack", ack, 1);
    send_byte(a, ack);
    chk(ack, "R3 addr ack", ack, 1);
    send_byte(d, ack);
    chk(ack == !wp_on, wp_on ? "R6 data nack" : "R3 data ack", ack, !wp_on);
    chk(we_cnt - we0 == (wp_on ? 0 : 1), wp_on ? "R6 no strobe" : "R4 strobe before stop",
        we_cnt - we0, wp_on ? 0 : 1);
    bus_stop();
    wcyc(4);
    chk(nv_cnt - nv0 == (wp_on ? 0 : 1), wp_on ? "R6 no nv" : "R5 nv pulse",
        nv_cnt - nv0, wp_on ? 0 : 1);
    if (!wp_on && a <= 8'(LAST)) begin
      exp_mem[a] = d;
      chk(mem[a] == d, "R3 stored data", mem[a], d);
    end
    wp_n = 1'b1;
  endtask

  task automatic do_read(input int a, input int n);
    bit ack;
    logic [7:0] d;
    int p, nv0;
    nv0 = nv_cnt;
    p = a;
    bus_start();
    send_byte({4'b1010, strap, 1'b0}, ack);
    chk(ack, "R2 id ack", ack, 1);
    send_byte(8'(a), ack);
    chk(ack, "R7 addr ack", ack, 1);
    bus_start();
    send_byte({4'b1010, strap, 1'b1}, ack);
    chk(ack, "R2 read id ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, d);
      chk(d == exp_mem[p], (p == 0 && k > 0) ? "R8 wrap data" : "R7 read data", d, exp_mem[p]);
      p = nxt(p);
    end
    bus_stop();
    wcyc(4);
    chk(nv_cnt == nv0, "R5 no nv after read", nv_cnt - nv0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    int low_seen, we0, nv0;
    logic [7:0] d;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i <= LAST; i++) begin
      mem[i] = 8'($urandom);
      exp_mem[i] = mem[i];
    end
    wcyc(5);
    rst_n = 1'b1;
    wcyc(5);
    chk(sda_oe == 1'b0 && we == 1'b0 && nv == 1'b0, "R1 reset idle", {sda_oe, we, nv}, 0);

    // directed: wrap across LAST_LOC
    strap = 3'b101;
    do_write(8'd8, 8'h5a, 1'b0);
    do_write(8'd0, 8'ha3, 1'b0);
    do_read(7, 4);

    // R9: master NACK then extra clocks, SDA must stay released
    do_write(8'd2, 8'h00, 1'b0);
    bus_start();
    send_byte({4'b1010, strap, 1'b0}, ack);
    send_byte(8'd2, ack);
    bus_start();
    send_byte({4'b1010, strap, 1'b1}, ack);
    recv_byte(1'b0, d);
    chk(d == 8'h00, "R7 zero byte", d, 0);
    low_seen = 0;
    for (int i = 0; i < 18; i++) begin
      wcyc(Q); scl = 1'b1; wcyc(Q/2);
      if (!sda_bus) low_seen++;
      wcyc(Q/2); scl = 1'b0;
    end
    chk(low_seen == 0, "R9 released after nack", low_seen, 0);
    bus_stop();

    // R12: wrong strap, later bytes ignored
    we0 = we_cnt;
    bus_start();
    send_byte({4'b1010, strap ^ 3'b010, 1'b0}, ack);
    chk(!ack, "R12 bad id nack", ack, 0);
    send_byte(8'd3, ack);
    chk(!ack, "R12 addr ignored", ack, 0);
    send_byte(8'h77, ack);
    chk(!ack && we_cnt == we0, "R12 data ignored", we_cnt - we0, 0);
    bus_stop();
    // wrong prefix
    bus_start();
    send_byte({4'b1011, strap, 1'b0}, ack);
    chk(!ack, "R2 bad prefix nack", ack, 0);
    bus_stop();

    // R10: busy rising together with the START
    we0 = we_cnt; nv0 = nv_cnt;
    m_low = 1'b0; wcyc(Q); scl = 1'b1; wcyc(Q);
    m_low = 1'b1; busy = 1'b1; wcyc(Q);
    scl = 1'b0; wcyc(Q);
    send_byte({4'b1010, strap, 1'b0}, ack);
    chk(!ack, "R10 busy id nack", ack, 0);
    send_byte(8'd4, ack);
    send_byte(8'h11, ack);
    bus_stop();
    wcyc(4);
    chk(we_cnt == we0 && nv_cnt == nv0 && sda_oe == 1'b0, "R10 busy quiet",
        we_cnt - we0 + nv_cnt - nv0, 0);
    busy = 1'b0;
    wcyc(Q);

    // R11: STOP in the middle of a byte
    bus_start();
    for (int i = 0; i < 4; i++) clk_bit(i[0]);
    bus_stop();
    do_write(8'd5, 8'hc6, 1'b0);
    do_read(5, 1);

    // R6 directed
    do_write(8'd6, 8'hee, 1'b1);
    do_read(6, 1);

    // random mix
    for (int it = 0; it < 30; it++) begin
      strap = 3'($urandom);
      if ($urandom_range(0, 9) < 6)
        do_write(8'($urandom_range(0, LAST)), 8'($urandom), $urandom_range(0, 4) == 0);
      else
        do_read($urandom_range(0, LAST), $urandom_range(1, 8));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule